// File: doc/BRIEF.md
# x86 Memory Operand Address Decoder

This block sits behind an instruction opcode decoder and walks the bytes that describe a memory operand, one byte per cycle under a valid/ready handshake. The first byte may be a segment-override prefix; after it comes the ModR/M byte, then an optional SIB byte, then a little-endian displacement of 0, 1, 2 or 4 bytes. The decoder handles both 16-bit and 32-bit address sizes. The `addr32_i` input selects between them and must stay steady for the whole operand.

When the last byte of an operand has been taken, the block raises `done_o` for one cycle. In that cycle it presents a breakdown of the operand:
- the base register and the index register, each with a valid flag;
- the scale field;
- the displacement, sign-extended to 32 bits;
- the effective segment;
- a register-direct flag;
- the number of bytes consumed, counting the prefix.

The irregular cases are resolved in hardware: the SIB escape, the "no index" code, the absolute-address forms, and the stack-segment default for frame-pointer and stack-pointer bases. Computing the address itself is left to the consumer.

Top module: `x86_mem_operand_dec`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `done_o` is 0 and `ready_o` is 1.
- R2: A ModR/M byte with mod (bits 7:6) = 11 completes the operand at once. The outputs show `reg_direct_o`=1, both valid flags at 0, displacement 0 and scale 0.
- R3: In 32-bit mode, when mod is not 11 and r/m (bits 2:0) is not 100, the base is the r/m value in register numbering eax=0, ecx=1, edx=2, ebx=3, esp=4, ebp=5, esi=6, edi=7. The displacement depends on mod: 00 gives none, except for the case in R4. 01 gives one byte, sign-extended. 10 gives four bytes, least significant first.
- R4: In 32-bit mode, mod=00 with r/m=101 means no base, a 4-byte absolute displacement, and segment DS.
- R5: In 32-bit mode, r/m=100 with mod other than 11 makes the next byte an SIB byte. The SIB byte is split as scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The scale appears on `scale_o`, the index on `index_o` and the base on `base_o`.
- R6: An SIB index field of 100 yields `index_vld_o`=0.
- R7: An SIB base of 101 with mod=00 means no base plus a 4-byte displacement in DS. With mod 01 or 10 it means base ebp (5) in SS.
- R8: Segment numbering is ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. In 32-bit mode the default is SS for an esp base or an ebp base, and DS otherwise.
- R9: In 16-bit mode the r/m forms are as follows:

  | r/m | Base | Index |
  |---|---|---|
  | 000 | bx (3) | si (6) |
  | 001 | bx (3) | di (7) |
  | 010 | bp (5) | si (6) |
  | 011 | bp (5) | di (7) |
  | 100 | si (6) | none |
  | 101 | di (7) | none |
  | 110 | bp (5) | none |
  | 111 | bx (3) | none |

  Forms 010, 011 and 110 default to SS. mod=01 gives a 1-byte displacement and mod=10 a 2-byte displacement, both sign-extended. mod=00 with r/m=110 is an absolute 2-byte displacement with no base, in DS.
- R10: The first byte of an operand is taken as a segment-override prefix if it equals one of 26h (ES), 2Eh (CS), 36h (SS), 3Eh (DS), 64h (FS) or 65h (GS). The override replaces the default segment. Only one prefix is taken, so the byte after a prefix is always the ModR/M byte.
- R11: `len_o` equals prefix (0/1) + 1 + SIB (0/1) + displacement bytes.
- R12: A byte is consumed only in a cycle where `valid_i` and `ready_o` are both high. `done_o` is high for exactly the one cycle after the last byte is consumed. In that cycle `ready_o` is 0, and the result fields are valid only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| byte_i | input | 8 | Operand stream byte |
| valid_i | input | 1 | byte_i holds a byte |
| ready_o | output | 1 | Block accepts a byte this cycle |
| done_o | output | 1 | Operand complete, result fields valid |
| reg_direct_o | output | 1 | Register-direct form (mod=11) |
| base_vld_o | output | 1 | A base register is used |
| base_o | output | 3 | Base register number |
| index_vld_o | output | 1 | An index register is used |
| index_o | output | 3 | Index register number |
| scale_o | output | 2 | SIB scale field (0 without SIB) |
| disp_o | output | 32 | Sign-extended displacement |
| seg_o | output | 3 | Effective segment number |
| len_o | output | 4 | Bytes consumed for the operand |

## Verification
Two decisions can land on the same byte, and the bench aims at those collisions. The first is the choice between prefix and ModR/M: the byte 26h is sent both as a prefix and straight after it, where it must be read as ModR/M (a 16-bit absolute form). The second is the point where an override meets a default: an override replaces the SS default that an ebp-based or esp-based operand would otherwise get. Each case is judged against a behavioural model that rebuilds the expected fields from the byte list. On every clock the bench compares `done_o` and `ready_o` with the cycle the model predicts. During the done cycle it also drives a prefix byte with valid high; since that byte must not be taken, the result of the following operand shows whether it was.

// File: rtl/adec_pkg.sv
package adec_pkg;
  typedef enum logic [2:0] {
    SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
    SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_e;

  typedef enum logic [2:0] {
    S_FIRST, S_MODRM, S_SIB, S_DISP, S_DONE
  } adec_st_e;

  typedef struct packed {
    logic       reg_dir;
    logic       base_vld;
    logic [2:0] base;
    logic       idx_vld;
    logic [2:0] idx;
    logic [1:0] scale;
    logic       need_sib;
    logic [2:0] disp_len;
    seg_e       def_seg;
  } mem_form_t;
endpackage

// File: rtl/adec_prefix.sv
module adec_prefix
  import adec_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output seg_e       seg_o
);
  always_comb begin
    hit_o = 1'b1;
    seg_o = SEG_DS;
    unique case (byte_i)
      8'h26:   seg_o = SEG_ES;
      8'h2E:   seg_o = SEG_CS;
      8'h36:   seg_o = SEG_SS;
      8'h3E:   seg_o = SEG_DS;
      8'h64:   seg_o = SEG_FS;
      8'h65:   seg_o = SEG_GS;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adec_form.sv
module adec_form
  import adec_pkg::*;
#(
  parameter int W_DISP_BYTES = 4
) (
  input  logic       addr32_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  input  logic [7:0] sib_i,
  output mem_form_t  form_o
);
  localparam logic [2:0] L32 = 3'(W_DISP_BYTES);
  localparam logic [2:0] L16 = 3'(W_DISP_BYTES / 2);

  logic [1:0] sib_sc;
  logic [2:0] sib_ix, sib_bs;
  logic [2:0] mod_len;
  assign sib_sc = sib_i[7:6];
  assign sib_ix = sib_i[5:3];
  assign sib_bs = sib_i[2:0];

  always_comb begin
    unique case (mod_i)
      2'b01:   mod_len = 3'd1;
      2'b10:   mod_len = addr32_i ? L32 : L16;
      default: mod_len = 3'd0;
    endcase
  end

  always_comb begin
    form_o          = '0;
    form_o.def_seg  = SEG_DS;
    form_o.disp_len = mod_len;
    if (mod_i == 2'b11) begin
      form_o.reg_dir  = 1'b1;
      form_o.disp_len = 3'd0;
    end else if (addr32_i) begin
      if (rm_i == 3'd4) begin
        form_o.need_sib = 1'b1;
        form_o.scale    = sib_sc;
        form_o.idx_vld  = (sib_ix != 3'd4);
        form_o.idx      = (sib_ix != 3'd4) ? sib_ix : 3'd0;
        if (sib_bs == 3'd5 && mod_i == 2'b00) begin
          form_o.disp_len = L32;
        end else begin
          form_o.base_vld = 1'b1;
          form_o.base     = sib_bs;
          if (sib_bs == 3'd4 || sib_bs == 3'd5) form_o.def_seg = SEG_SS;
        end
      end else if (rm_i == 3'd5 && mod_i == 2'b00) begin
        form_o.disp_len = L32;
      end else begin
        form_o.base_vld = 1'b1;
        form_o.base     = rm_i;
        if (rm_i == 3'd5) form_o.def_seg = SEG_SS;
      end
    end else begin
      if (rm_i == 3'd6 && mod_i == 2'b00) begin
        form_o.disp_len = L16;
      end else begin
        form_o.base_vld = 1'b1;
        // bx=3 bp=5 si=6 di=7
        unique case (rm_i)
          3'd0, 3'd1, 3'd7: form_o.base = 3'd3;
          3'd2, 3'd3, 3'd6: form_o.base = 3'd5;
          3'd4:             form_o.base = 3'd6;
          default:          form_o.base = 3'd7;
        endcase
        if (!rm_i[2]) begin
          form_o.idx_vld = 1'b1;
          form_o.idx     = rm_i[0] ? 3'd7 : 3'd6;
        end
        if (rm_i == 3'd2 || rm_i == 3'd3 || rm_i == 3'd6) form_o.def_seg = SEG_SS;
      end
    end
  end
endmodule

// File: rtl/adec_disp.sv
module adec_disp #(
  parameter int NBYTES = 4,
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int W  = 8 * NBYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    byte_i,
  input  logic [2:0]    len_i,
  output logic [W-1:0]  disp_o
);
  logic [NBYTES-1:0][7:0] b_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          b_q[k] <= '0;
      else if (clr_i)                       b_q[k] <= '0;
      else if (wr_i && idx_i == IW'(k))     b_q[k] <= byte_i;
    end
  end

  logic sgn;
  always_comb begin
    sgn = 1'b0;
    for (int k = 0; k < NBYTES; k++)
      if (32'(len_i) == k + 1) sgn = b_q[k][7];
    for (int k = 0; k < NBYTES; k++)
      disp_o[8*k +: 8] = (k < 32'(len_i)) ? b_q[k] : {8{sgn}};
  end
endmodule

// File: rtl/x86_mem_operand_dec.sv
module x86_mem_operand_dec
  import adec_pkg::*;
#(
  parameter int DISP_BYTES = 4,
  localparam int DW  = 8 * DISP_BYTES,
  localparam int CW  = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr32_i,
  input  logic [7:0]    byte_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          reg_direct_o,
  output logic          base_vld_o,
  output logic [2:0]    base_o,
  output logic          index_vld_o,
  output logic [2:0]    index_o,
  output logic [1:0]    scale_o,
  output logic [DW-1:0] disp_o,
  output logic [2:0]    seg_o,
  output logic [3:0]    len_o
);
  adec_st_e  st_q, st_d;
  logic      ovr_vld_q;
  seg_e      ovr_seg_q;
  logic [4:0] mrm_q;
  logic [7:0] sib_q;
  logic [CW-1:0] dcnt_q;

  logic acc, in_mrm, pfx_hit;
  logic take_pfx, take_mrm, take_sib, take_disp, last_disp;
  seg_e pfx_seg;
  logic [4:0] cur_mrm;
  logic [7:0] cur_sib;
  mem_form_t form;

  assign ready_o = (st_q != S_DONE);
  assign acc     = valid_i && ready_o;
  assign in_mrm  = (st_q == S_FIRST) || (st_q == S_MODRM);
  assign cur_mrm = in_mrm ? {byte_i[7:6], byte_i[2:0]} : mrm_q;
  assign cur_sib = (st_q == S_SIB) ? byte_i : sib_q;

  adec_prefix u_pfx (.byte_i(byte_i), .hit_o(pfx_hit), .seg_o(pfx_seg));

  adec_form #(.W_DISP_BYTES(DISP_BYTES)) u_form (
    .addr32_i(addr32_i), .mod_i(cur_mrm[4:3]), .rm_i(cur_mrm[2:0]),
    .sib_i(cur_sib), .form_o(form)
  );

  assign take_pfx  = acc && (st_q == S_FIRST) && pfx_hit;
  assign take_mrm  = acc && (((st_q == S_FIRST) && !pfx_hit) || (st_q == S_MODRM));
  assign take_sib  = acc && (st_q == S_SIB);
  assign take_disp = acc && (st_q == S_DISP);
  assign last_disp = (3'(dcnt_q) + 3'd1) == form.disp_len;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_FIRST, S_MODRM: begin
        if (take_pfx)      st_d = S_MODRM;
        else if (take_mrm) st_d = form.need_sib ? S_SIB :
                                  (form.disp_len != 3'd0) ? S_DISP : S_DONE;
      end
      S_SIB:   if (take_sib) st_d = (form.disp_len != 3'd0) ? S_DISP : S_DONE;
      S_DISP:  if (take_disp && last_disp) st_d = S_DONE;
      default: st_d = S_FIRST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_FIRST;
      ovr_vld_q <= 1'b0;
      ovr_seg_q <= SEG_DS;
      mrm_q     <= '0;
      sib_q     <= '0;
      dcnt_q    <= '0;
    end else begin
      st_q <= st_d;
      if (take_pfx) begin
        ovr_vld_q <= 1'b1;
        ovr_seg_q <= pfx_seg;
      end else if (take_mrm && st_q == S_FIRST) begin
        ovr_vld_q <= 1'b0;
      end
      if (take_mrm) begin
        mrm_q  <= cur_mrm;
        sib_q  <= '0;
        dcnt_q <= '0;
      end
      if (take_sib)  sib_q  <= byte_i;
      if (take_disp) dcnt_q <= dcnt_q + CW'(1);
    end
  end

  adec_disp #(.NBYTES(DISP_BYTES)) u_disp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(take_mrm), .wr_i(take_disp),
    .idx_i(dcnt_q), .byte_i(byte_i), .len_i(form.disp_len), .disp_o(disp_o)
  );

  assign done_o       = (st_q == S_DONE);
  assign reg_direct_o = form.reg_dir;
  assign base_vld_o   = form.base_vld;
  assign base_o       = form.base;
  assign index_vld_o  = form.idx_vld;
  assign index_o      = form.idx;
  assign scale_o      = form.scale;
  assign seg_o        = ovr_vld_q ? ovr_seg_q : form.def_seg;
  assign len_o        = 4'(ovr_vld_q) + 4'd1 + 4'(form.need_sib) + 4'(form.disp_len);
endmodule

// File: rtl/x86_mem_operand_dec_chk.sv
module x86_mem_operand_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        ready_o,
  input logic        done_o,
  input logic        reg_direct_o,
  input logic        base_vld_o,
  input logic        index_vld_o,
  input logic [2:0]  index_o,
  input logic [1:0]  scale_o,
  input logic [31:0] disp_o,
  input logic [2:0]  seg_o,
  input logic [3:0]  len_o
);
  p_done_after_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && ready_o));
  p_done_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_regdir_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && reg_direct_o) |-> (!base_vld_o && !index_vld_o && disp_o == 32'd0 && scale_o == 2'd0 && len_o <= 4'd2));
  p_no_esp_index_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && index_vld_o) |-> (index_o != 3'd4));
  p_seg_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (seg_o <= 3'd5));
  p_len_bounds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= 4'd1 && len_o <= 4'd7));
endmodule

bind x86_mem_operand_dec x86_mem_operand_dec_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .done_o(done_o), .reg_direct_o(reg_direct_o), .base_vld_o(base_vld_o),
  .index_vld_o(index_vld_o), .index_o(index_o), .scale_o(scale_o),
  .disp_o(disp_o), .seg_o(seg_o), .len_o(len_o)
);

// File: tb/tb_x86_mem_operand_dec.sv
`timescale 1ns/1ps
module tb_x86_mem_operand_dec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr32_i = 1'b1;
  logic [7:0]  byte_i = 8'h00;
  logic        valid_i = 1'b0;
  logic        ready_o, done_o, reg_direct_o, base_vld_o, index_vld_o;
  logic [2:0]  base_o, index_o, seg_o;
  logic [1:0]  scale_o;
  logic [31:0] disp_o;
  logic [3:0]  len_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  x86_mem_operand_dec dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr32_i(addr32_i), .byte_i(byte_i),
    .valid_i(valid_i), .ready_o(ready_o), .done_o(done_o),
    .reg_direct_o(reg_direct_o), .base_vld_o(base_vld_o), .base_o(base_o),
    .index_vld_o(index_vld_o), .index_o(index_o), .scale_o(scale_o),
    .disp_o(disp_o), .seg_o(seg_o), .len_o(len_o)
  );

  logic [7:0] bq[$];
  int e_rd, e_bv, e_b, e_iv, e_i, e_sc, e_seg, e_len;
  logic [31:0] e_disp;
  string e_tag;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void model(bit a32);
    int p, m, md, rm, dl, s, sb, si, ovr, dseg;
    int b16[8] = '{3, 3, 5, 5, 6, 7, 5, 3};
    logic [31:0] v;
    p = 0; ovr = -1; dseg = 3;
    e_rd = 0; e_bv = 0; e_b = 0; e_iv = 0; e_i = 0; e_sc = 0;
    case (bq[0])
      8'h26: ovr = 0;  8'h2E: ovr = 1;  8'h36: ovr = 2;
      8'h3E: ovr = 3;  8'h64: ovr = 4;  8'h65: ovr = 5;
      default: ovr = -1;
    endcase
    if (ovr >= 0) p = 1;
    m = int'(bq[p]); p++;
    md = m / 64; rm = m % 8;
    dl = 0;
    if (md == 3) begin
      e_rd = 1;
    end else if (a32) begin
      dl = (md == 1) ? 1 : (md == 2) ? 4 : 0;
      if (rm == 4) begin
        s = int'(bq[p]); p++;
        e_sc = s / 64; si = (s / 8) % 8; sb = s % 8;
        if (si != 4) begin e_iv = 1; e_i = si; end
        if (sb == 5 && md == 0) dl = 4;
        else begin
          e_bv = 1; e_b = sb;
          if (sb == 4 || sb == 5) dseg = 2;
        end
      end else if (rm == 5 && md == 0) begin
        dl = 4;
      end else begin
        e_bv = 1; e_b = rm;
        if (rm == 5) dseg = 2;
      end
    end else begin
      dl = (md == 1) ? 1 : (md == 2) ? 2 : 0;
      if (md == 0 && rm == 6) dl = 2;
      else begin
        e_bv = 1; e_b = b16[rm];
        if (rm < 4) begin e_iv = 1; e_i = (rm % 2 == 1) ? 7 : 6; end
        if (rm == 2 || rm == 3 || rm == 6) dseg = 2;
      end
    end
    v = 32'd0;
    for (int k = 0; k < dl; k++) v = v | (32'(bq[p + k]) << (8 * k));
    if (dl == 1 && v[7])  v = v | 32'hFFFF_FF00;
    if (dl == 2 && v[15]) v = v | 32'hFFFF_0000;
    e_disp = v;
    e_len = p + dl;
    e_seg = (ovr >= 0) ? ovr : dseg;
  endfunction

  task automatic run(bit a32, string tag);
    int n;
    addr32_i = a32;
    model(a32);
    n = bq.size();
    for (int i = 0; i < n; i++) begin
      int gaps = $urandom_range(0, 2);
      for (int g = 0; g < gaps; g++) begin
        valid_i = 1'b0;
        byte_i = 8'h26;
        @(negedge clk_i);
        chk("R12", {tag, " idle done"}, 32'(done_o), 32'd0);
        chk("R12", {tag, " idle ready"}, 32'(ready_o), 32'd1);
      end
      valid_i = 1'b1;
      byte_i = bq[i];
      @(negedge clk_i);
      if (i == n - 1) begin
        chk("R12", {tag, " done"}, 32'(done_o), 32'd1);
        chk("R12", {tag, " ready low"}, 32'(ready_o), 32'd0);
        chk(e_tag, {tag, " regdir"}, 32'(reg_direct_o), 32'(e_rd));
        chk(e_tag, {tag, " base_vld"}, 32'(base_vld_o), 32'(e_bv));
        if (e_bv != 0) chk(e_tag, {tag, " base"}, 32'(base_o), 32'(e_b));
        chk(e_tag, {tag, " idx_vld"}, 32'(index_vld_o), 32'(e_iv));
        if (e_iv != 0) chk(e_tag, {tag, " idx"}, 32'(index_o), 32'(e_i));
        chk(e_tag, {tag, " scale"}, 32'(scale_o), 32'(e_sc));
        chk(e_tag, {tag, " disp"}, disp_o, e_disp);
        chk(e_tag, {tag, " seg"}, 32'(seg_o), 32'(e_seg));
        chk("R11", {tag, " len"}, 32'(len_o), 32'(e_len));
      end else begin
        chk("R12", {tag, " early done"}, 32'(done_o), 32'd0);
      end
    end
    // R12: a valid prefix in the done cycle must not be taken
    valid_i = 1'b1;
    byte_i = 8'h65;
    @(negedge clk_i);
    chk("R12", {tag, " one-cycle done"}, 32'(done_o), 32'd0);
    chk("R12", {tag, " ready back"}, 32'(ready_o), 32'd1);
    valid_i = 1'b0;
    bq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "ready in reset", 32'(ready_o), 32'd1);
    chk("R1", "done in reset", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ready after reset", 32'(ready_o), 32'd1);
    chk("R1", "done after reset", 32'(done_o), 32'd0);

    e_tag = "R2";  bq = '{8'hC1};                                run(1, "r2_reg32");
    e_tag = "R2";  bq = '{8'hFF};                                run(0, "r2_reg16");
    e_tag = "R3";  bq = '{8'h03};                                run(1, "r3_ebx");
    e_tag = "R8";  bq = '{8'h45, 8'h80};                         run(1, "r8_ebp_d8");
    e_tag = "R3";  bq = '{8'h86, 8'h78, 8'h56, 8'h34, 8'h12};    run(1, "r3_esi_d32");
    e_tag = "R4";  bq = '{8'h05, 8'hEF, 8'hBE, 8'hAD, 8'hDE};    run(1, "r4_abs32");
    e_tag = "R5";  bq = '{8'h04, 8'h8C};                         run(1, "r5_sib_esp");
    e_tag = "R6";  bq = '{8'h04, 8'h20};                         run(1, "r6_noidx");
    e_tag = "R7";  bq = '{8'h04, 8'hF5, 8'h00, 8'h10, 8'h00, 8'h80}; run(1, "r7_sib_abs");
    e_tag = "R7";  bq = '{8'h44, 8'h2D, 8'h7F};                  run(1, "r7_sib_ebp");
    e_tag = "R10"; bq = '{8'h64, 8'h84, 8'h24, 8'h01, 8'h02, 8'h03, 8'h04}; run(1, "r10_fs_max");
    e_tag = "R10"; bq = '{8'h3E, 8'h45, 8'h10};                  run(1, "r10_ds_over_ss");
    e_tag = "R10"; bq = '{8'h2E, 8'h01};                         run(1, "r10_cs");
    e_tag = "R10"; bq = '{8'h36, 8'h07};                         run(0, "r10_ss16");
    e_tag = "R10"; bq = '{8'h65, 8'h00};                         run(0, "r10_gs16");
    e_tag = "R10"; bq = '{8'h26, 8'h26, 8'h34, 8'h12};           run(0, "r10_pfx_then_26");
    e_tag = "R9";  bq = '{8'h02};                                run(0, "r9_bp_si");
    e_tag = "R9";  bq = '{8'h06, 8'h34, 8'h12};                  run(0, "r9_abs16");
    e_tag = "R9";  bq = '{8'h87, 8'h00, 8'h80};                  run(0, "r9_bx_d16");
    e_tag = "R9";  bq = '{8'h46, 8'hFF};                         run(0, "r9_bp_d8");
    for (int r = 0; r < 8; r++) begin
      e_tag = "R9";
      bq = '{8'(8'h40 | r), 8'($urandom)};
      run(0, "r9_sweep");
      bq = '{8'(8'h80 | r), 8'($urandom), 8'($urandom)};
      run(0, "r9_sweep16");
      bq = '{8'(r)}; if (r == 6) bq.push_back(8'h99); if (r == 6) bq.push_back(8'h88);
      run(0, "r9_mod0");
      if (r != 4) begin
        e_tag = "R3";
        bq = '{8'(8'h80 | (r << 3) | r), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
        run(1, "r3_sweep");
      end
    end
    for (int s = 0; s < 16; s++) begin
      e_tag = "R5";
      bq = '{8'h44, 8'($urandom), 8'($urandom)};
      run(1, "r5_rand_sib");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule